// File: doc/BRIEF.md
# Test-Tone DAC Formatter and Capture Trigger

This block takes two signed tone samples and adds them at full precision. It turns the signed sum into the unsigned offset-binary code that an external DAC expects, and it drives the DAC pins straight from a flop. A signed value of zero therefore leaves the block as mid-scale, 0x2000.

A separate settling counter runs only while its enable input is high. It gives a single-cycle arm pulse once per counter period. An on-chip capture unit triggers on the falling edge of that pulse. If the enable is raised only after a reset pulse, the first trigger edge cannot come before the analog path has settled.

A third path combines the expiry flags of several cores into one active-low status line. That line drives an LED.

Top module: `tone_dac_trigger`

## Requirements
- R1: The sum of `tone_a` and `tone_b` (13-bit two's complement each) is formed at 14 bits with no wrap, so the extremes -8192 and +8190 are both representable.
- R2: `dac_code` equals the 14-bit sum with its top bit (bit 13) inverted. This is the same as sum + 8192 in unsigned form, so a zero sum gives 8192 and a sum of -8192 gives 0.
- R3: `dac_code` is registered. A change on the tone inputs reaches it after exactly one rising clock edge, and it does not change between edges.
- R4: While `rst` is high at a rising edge, `dac_code` becomes 8192, the counter clears and `arm_pulse` goes low.
- R5: While `cnt_en` is low, the counter holds its value and `arm_pulse` stays low.
- R6: `arm_pulse` is high for exactly one cycle. Its rising edges are 4095 enabled clock edges apart; the counter runs 0 to 4094 and then wraps to 0.
- R7: If `cnt_en` goes high in the first cycle after reset, the first `arm_pulse` appears after the 4095th enabled edge. Its falling edge therefore comes at least 4095 cycles after reset.
- R8: `status_led_n` is high while every bit of `core_expired` is low, and low while any bit is high. With the default (combinational) option it follows the flags in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| tone_a | input | 13 | First tone sample, signed |
| tone_b | input | 13 | Second tone sample, signed |
| cnt_en | input | 1 | Enable for the settling counter |
| core_expired | input | 3 | Expiry flags from the cores, active high |
| dac_code | output | 14 | Offset-binary code for the DAC, registered |
| arm_pulse | output | 1 | One-cycle pulse per counter period; its falling edge arms capture |
| status_led_n | output | 1 | Active-low expiry indication for an LED |

## Verification
The DAC code is due one rising edge after the tone inputs change. The bench drives inputs on the falling edge and reads `dac_code` at the next falling edge. It also reads it just after driving, to confirm the old value is still held.

The arm pulse is checked by counting enabled rising edges from reset. Each falling-edge sample is compared against the expected edge number: high after edges 4095 and 8190, low on the neighbouring samples. Edges taken while the enable is low are left out of the count.

The status line is combinational by default, so it is sampled a short delay after the flags are driven, with no clock edge in between.

// File: rtl/tone_fmt_pkg.sv
package tone_fmt_pkg;
   localparam int DEF_TONE_W = 13;
   localparam int DEF_PERIOD = 4095;
   localparam int DEF_CORES  = 3;

   // Count width that holds values 0 .. period-1
   function automatic int cnt_width(input int period);
      return (period <= 2) ? 1 : $clog2(period);
   endfunction
endpackage

// File: rtl/tone_dac_formatter.sv
module tone_dac_formatter #(
   parameter int TONE_W = tone_fmt_pkg::DEF_TONE_W
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic signed [TONE_W-1:0] in_a,
   input  logic signed [TONE_W-1:0] in_b,
   output logic        [TONE_W:0]   code_q
);
   localparam int SUM_W = TONE_W + 1;
   localparam logic [SUM_W-1:0] MID = {1'b1, {(SUM_W-1){1'b0}}};

   generate
      if (TONE_W < 2) begin : g_bad_w
         $error("tone_dac_formatter: TONE_W must be at least 2");
      end
   endgenerate

   logic signed [SUM_W-1:0] sum_s;
   logic        [SUM_W-1:0] ofs_code;

   // Full-precision sum: one guard bit, no wrap possible
   always_comb begin
      sum_s    = SUM_W'(in_a) + SUM_W'(in_b);
      ofs_code = {~sum_s[SUM_W-1], sum_s[SUM_W-2:0]};
   end

   // Output flop keeps the pin path short
   always_ff @(posedge clk) begin
      if (rst) code_q <= MID;
      else     code_q <= ofs_code;
   end

   // R2 / R3: code one edge later equals the previous inputs plus the mid-scale offset
   assert_code_follows_R2: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (code_q == SUM_W'(SUM_W'($past(in_a)) + SUM_W'($past(in_b)) + MID)));

   // R4: reset leaves mid-scale on the pins
   assert_reset_mid_R4: assert property (@(posedge clk)
      $past(rst) |-> (code_q == MID));
endmodule

// File: rtl/settle_counter.sv
module settle_counter #(
   parameter int PERIOD = tone_fmt_pkg::DEF_PERIOD
) (
   input  logic clk,
   input  logic rst,
   input  logic en,
   output logic pulse_q
);
   localparam int CNT_W = tone_fmt_pkg::cnt_width(PERIOD);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

   generate
      if (PERIOD < 2) begin : g_bad_p
         $error("settle_counter: PERIOD must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic             at_last;

   assign at_last = (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q   <= '0;
         pulse_q <= 1'b0;
      end else if (en) begin
         cnt_q   <= at_last ? '0 : cnt_q + 1'b1;
         pulse_q <= at_last;
      end else begin
         pulse_q <= 1'b0;
      end
   end

   // R5: count frozen while disabled
   assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(cnt_q));

   // R5: no pulse follows a disabled edge
   assert_gated_R5: assert property (@(posedge clk) disable iff (rst)
      (!en && !rst) |=> !pulse_q);

   // R6: pulse lasts one cycle
   assert_single_R6: assert property (@(posedge clk) disable iff (rst)
      pulse_q |=> !pulse_q);

   // R6: count never passes the terminal value
   assert_range_R6: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= LAST);

   // R6: a pulse is always followed by a count of zero
   assert_wrap_R6: assert property (@(posedge clk) disable iff (rst)
      pulse_q |-> (cnt_q == '0));
endmodule

// File: rtl/expiry_combiner.sv
module expiry_combiner #(
   parameter int N_CORES = tone_fmt_pkg::DEF_CORES,
   parameter bit REG_OUT = 1'b0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [N_CORES-1:0] flags,
   output logic               ok_n
);
   generate
      if (N_CORES < 1) begin : g_bad_n
         $error("expiry_combiner: N_CORES must be at least 1");
      end

      if (REG_OUT) begin : g_flop
         always_ff @(posedge clk) begin
            if (rst) ok_n <= 1'b1;
            else     ok_n <= ~(|flags);
         end
         // R8: any flag pulls the line low one edge later
         assert_any_low_R8: assert property (@(posedge clk) disable iff (rst)
            (|flags) |=> !ok_n);
      end else begin : g_comb
         assign ok_n = ~(|flags);
         // R8: quiet flags keep the line high
         assert_quiet_high_R8: assert property (@(posedge clk) disable iff (rst)
            (flags == '0) |-> ok_n);
      end
   endgenerate
endmodule

// File: rtl/tone_dac_trigger.sv
module tone_dac_trigger #(
   parameter int TONE_W     = tone_fmt_pkg::DEF_TONE_W,
   parameter int PERIOD     = tone_fmt_pkg::DEF_PERIOD,
   parameter int N_CORES    = tone_fmt_pkg::DEF_CORES,
   parameter bit STATUS_REG = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic signed [TONE_W-1:0] tone_a,
   input  logic signed [TONE_W-1:0] tone_b,
   input  logic                     cnt_en,
   input  logic [N_CORES-1:0]       core_expired,
   output logic [TONE_W:0]          dac_code,
   output logic                     arm_pulse,
   output logic                     status_led_n
);
   tone_dac_formatter #(.TONE_W(TONE_W)) u_fmt (
      .clk(clk), .rst(rst), .in_a(tone_a), .in_b(tone_b), .code_q(dac_code)
   );

   settle_counter #(.PERIOD(PERIOD)) u_cnt (
      .clk(clk), .rst(rst), .en(cnt_en), .pulse_q(arm_pulse)
   );

   expiry_combiner #(.N_CORES(N_CORES), .REG_OUT(STATUS_REG)) u_exp (
      .clk(clk), .rst(rst), .flags(core_expired), .ok_n(status_led_n)
   );
endmodule

// File: tb/sim_tone_dac_trigger.sv
module sim_tone_dac_trigger;
   localparam int CLK_P = 10;
   localparam int NV    = 8;
   localparam int VA [NV] = '{0, 4095, -4096, 4095, 1, -1, 100, 2000};
   localparam int VB [NV] = '{0, 4095, -4096, -4096, 0, 0, -300, 1000};
   localparam int VE [NV] = '{8192, 16382, 0, 8191, 8193, 8191, 7992, 11192};

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic signed [12:0] tone_a = '0;
   logic signed [12:0] tone_b = '0;
   logic cnt_en = 1'b0;
   logic [2:0] core_expired = '0;
   logic [13:0] dac_code;
   logic arm_pulse;
   logic status_led_n;

   int checks = 0;
   int errors = 0;

   always #(CLK_P/2) clk = ~clk;

   tone_dac_trigger u0 (
      .clk(clk), .rst(rst), .tone_a(tone_a), .tone_b(tone_b), .cnt_en(cnt_en),
      .core_expired(core_expired), .dac_code(dac_code), .arm_pulse(arm_pulse),
      .status_led_n(status_led_n)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   initial begin
      #(CLK_P*150000);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int edges;
      int rise1;
      int rise2;
      // R4: reset state
      repeat (3) @(negedge clk);
      chk("R4 dac mid-scale", int'(dac_code), 8192);
      chk("R4 pulse low", int'(arm_pulse), 0);

      // R8: status line
      core_expired = 3'b000; #1;
      chk("R8 none expired", int'(status_led_n), 1);
      core_expired = 3'b010; #1;
      chk("R8 one expired", int'(status_led_n), 0);
      core_expired = 3'b101; #1;
      chk("R8 two expired", int'(status_led_n), 0);
      core_expired = 3'b000; #1;
      chk("R8 cleared", int'(status_led_n), 1);

      // R1 R2: vector table, one edge latency
      @(negedge clk);
      rst = 1'b0;
      for (int i = 0; i < NV; i++) begin
         tone_a = 13'(VA[i]);
         tone_b = 13'(VB[i]);
         @(negedge clk);
         chk("R1 R2 vector", int'(dac_code), VE[i]);
      end

      // R3: new inputs do not appear before the edge
      tone_a = 13'sd5; tone_b = 13'sd6; #1;
      chk("R3 held before edge", int'(dac_code), VE[NV-1]);
      @(negedge clk);
      chk("R3 updated after edge", int'(dac_code), 8203);

      // R4 / R7: fresh reset, then enable
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R4 dac back to mid", int'(dac_code), 8192);
      rst = 1'b0;
      cnt_en = 1'b1;
      edges = 0; rise1 = -1; rise2 = -1;
      for (int n = 0; n < 8200; n++) begin
         @(negedge clk);
         edges++;
         if (arm_pulse && rise1 < 0) rise1 = edges;
         else if (arm_pulse && rise2 < 0) rise2 = edges;
         if (edges == 4094) chk("R7 low before first", int'(arm_pulse), 0);
         if (edges == 4096) chk("R6 single cycle", int'(arm_pulse), 0);
      end
      chk("R7 first pulse edge", rise1, 4095);
      chk("R6 second pulse edge", rise2, 8190);

      // R5: stall for 40 cycles, pulse stays low, count resumes
      // after edge 8200 the count is 10; 4085 more enabled edges reach the next pulse
      cnt_en = 1'b0;
      for (int n = 0; n < 40; n++) begin
         @(negedge clk);
         if (arm_pulse) chk("R5 pulse while disabled", 1, 0);
      end
      chk("R5 no pulse while disabled", int'(arm_pulse), 0);
      cnt_en = 1'b1;
      edges = 0; rise1 = -1;
      for (int n = 0; n < 4100; n++) begin
         @(negedge clk);
         edges++;
         if (arm_pulse && rise1 < 0) rise1 = edges;
      end
      chk("R5 count held across stall", rise1, 4085);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule